// File: doc/BRIEF.md
# PCI-to-PCI Bridge Type-1 Configuration Registers

This block holds the bridge-specific configuration state of a PCI-to-PCI bridge: the three bus numbers, the secondary latency timer, the I/O, memory and prefetchable forwarding windows with their upper extensions, the command register and the bridge control register. Software reaches it through a dword-indexed configuration port. Writes carry four byte enables. A read returns the assembled dword one clock later. Fixed identification fields are built into the read path: the status words, the class code, the revision and the header type.

Two one-cycle event pulses go to the surrounding bridge logic. The remap pulse fires on any write whose enabled bytes land in a register that shapes forwarding, so the decoder can reload its windows. The secondary bus reset pulse fires only when software moves the bus-reset control bit from 0 to 1. A separate close-windows input forces every window empty (limit below base) in a single cycle.

Top module: `p2p_cfg_regs`

## Requirements
- R1: While reset is low, and after it is released, every writable field reads 0, `cfg_rdata` is 0 and both pulses are low.
- R2: A read with `cfg_rd` high at dword index N puts dword N on `cfg_rdata` at the next clock edge. `cfg_rdata` holds between reads. A read in the same cycle as a write to the same dword returns the value from before the write.
- R3: Dword 6 holds the primary bus (byte 0), secondary bus (byte 1), subordinate bus (byte 2) and secondary latency timer (byte 3). Each byte is fully writable and is written only when its byte enable is set.
- R4: The I/O base and limit bytes are bytes 0 and 1 of dword 7. Memory base/limit are the halves of dword 8, and prefetchable base/limit are the halves of dword 9. Only the address bits are writable: bits 7:4 of each I/O byte and bits 15:4 of each memory halfword. The low nibble reads 1 when 32-bit I/O (or 64-bit prefetch) is configured and 0 otherwise, and it ignores writes.
- R5: The prefetch base-upper (dword 10) and limit-upper (dword 11) registers are fully writable when 64-bit prefetch is configured. So are the I/O base-upper (dword 12 low half) and limit-upper (high half) registers when 32-bit I/O is configured. When the matching variant is not configured, these registers read 0.
- R6: The command register (dword 1, low half) has writable bits 2:0 and all other bits read 0. Bridge control (dword 15, high half) has write mask 0x004F: bit 6 is secondary bus reset and bit 3 is VGA enable. Unmasked bits read 0.
- R7: The primary status (dword 1 high half) and the secondary status (dword 7 high half) both read 0x00A0, i.e. 66 MHz capable and fast back-to-back capable. Dword 2 reads class 0x060400 above the revision byte. Dword 3 byte 2 reads the multifunction flag in bit 7 and type 0x01 below it. Writes to all of these have no effect.
- R8: `remap_pulse` is high for one cycle, at the edge after a write, when an enabled byte address of that write falls in 0x04–0x05, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F. It stays low after a write that touches none of these bytes.
- R9: `sec_bus_rst_pulse` is high for one cycle, at the edge after a write with byte enable 2 set to dword 15 that sets data bit 22, but only if bridge control bit 6 was 0 before the write. Rewriting the bit while it is already 1 gives no pulse.
- R10: A cycle with `fwd_disable` high works as follows. It sets every base address bit to 1 and clears every limit address bit in the I/O, memory and prefetch windows. It zeroes both prefetch upper registers. It leaves the I/O upper registers unchanged. It raises `remap_pulse` at the next edge. It discards a write in the same cycle, so that write changes no register and gives no bus reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Dword index into the 256-byte configuration space |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| fwd_disable | input | 1 | Close-all-windows action |
| cfg_rdata | output | 32 | Registered read data |
| remap_pulse | output | 1 | One-cycle forwarding-change event |
| sec_bus_rst_pulse | output | 1 | One-cycle secondary bus reset event |

## Verification
The byte-enable patterns used on the window dwords include full-dword, alternating-lane and single-lane writes. Together they show whether each lane lands in its own field and whether the type nibbles stay fixed. Writes are aimed at bytes just inside and just outside each forwarding span (the status half of dword 1, the secondary-status half of dword 7, the low half of dword 15, dword 13, and a write with no enables), which separates a correct overlap test from one keyed on the dword alone. The bus-reset bit is driven through 0→1, 1→1, 1→0 and 0→1 again, and also through lane 3 only, to show edge behaviour rather than level behaviour. A close-windows cycle is also issued together with a bit-setting write, to show that the action takes priority.

// File: rtl/p2p_cfg_pkg.sv
package p2p_cfg_pkg;

  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int IDX_W    = 6;
  localparam int WIN_W    = 12;
  localparam int UP_W     = 32;
  localparam int IOUP_W   = 16;
  localparam int CTL_W    = 16;
  localparam int CTL_SBR  = 6;

  localparam logic [IDX_W-1:0] DW_CMD  = 6'd1;
  localparam logic [IDX_W-1:0] DW_ID   = 6'd2;
  localparam logic [IDX_W-1:0] DW_HDR  = 6'd3;
  localparam logic [IDX_W-1:0] DW_BUS  = 6'd6;
  localparam logic [IDX_W-1:0] DW_IO   = 6'd7;
  localparam logic [IDX_W-1:0] DW_MEM  = 6'd8;
  localparam logic [IDX_W-1:0] DW_PF   = 6'd9;
  localparam logic [IDX_W-1:0] DW_PFBU = 6'd10;
  localparam logic [IDX_W-1:0] DW_PFLU = 6'd11;
  localparam logic [IDX_W-1:0] DW_IOU  = 6'd12;
  localparam logic [IDX_W-1:0] DW_CTL  = 6'd15;

  localparam logic [CTL_W-1:0]  CTL_WMASK = 16'h004F;
  localparam logic [15:0]       STAT_CAPS = 16'h00A0;
  localparam logic [23:0]       CLASS_P2P = 24'h060400;

  typedef struct packed {
    logic [2:0]        cmd;
    logic [7:0]        bus_pri;
    logic [7:0]        bus_sec;
    logic [7:0]        bus_sub;
    logic [7:0]        lat_sec;
    logic [3:0]        io_base;
    logic [3:0]        io_lim;
    logic [WIN_W-1:0]  mem_base;
    logic [WIN_W-1:0]  mem_lim;
    logic [WIN_W-1:0]  pf_base;
    logic [WIN_W-1:0]  pf_lim;
    logic [UP_W-1:0]   pf_base_up;
    logic [UP_W-1:0]   pf_lim_up;
    logic [IOUP_W-1:0] io_base_up;
    logic [IOUP_W-1:0] io_lim_up;
    logic [CTL_W-1:0]  ctl;
  } cfg_state_t;

  // True when any enabled byte of the access falls in a forwarding-relevant span.
  function automatic logic fwd_span_hit(logic [IDX_W-1:0] idx, logic [BE_W-1:0] be);
    logic hit;
    int   a;
    hit = 1'b0;
    for (int l = 0; l < BE_W; l++) begin
      a = int'(idx) * BE_W + l;
      if (be[l] && ((a >= 4 && a <= 5) || (a >= 28 && a <= 29) ||
                    (a >= 32 && a <= 51) || (a >= 62 && a <= 63)))
        hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/p2p_cfg_store.sv
module p2p_cfg_store
  import p2p_cfg_pkg::*;
#(
  parameter bit IO32   = 1'b1,
  parameter bit PREF64 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              dis,
  input  logic [IDX_W-1:0]  addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output cfg_state_t        st
);

  cfg_state_t st_q;
  cfg_state_t st_nx;
  logic       upd_en;

  assign upd_en = wr_go | dis;

  always_comb begin
    st_nx = st_q;
    if (dis) begin
      st_nx.io_base    = '1;
      st_nx.io_lim     = '0;
      st_nx.mem_base   = '1;
      st_nx.mem_lim    = '0;
      st_nx.pf_base    = '1;
      st_nx.pf_lim     = '0;
      st_nx.pf_base_up = '0;
      st_nx.pf_lim_up  = '0;
    end else if (wr_go) begin
      case (addr)
        DW_CMD: if (be[0]) st_nx.cmd = wdata[2:0];
        DW_BUS: begin
          if (be[0]) st_nx.bus_pri = wdata[7:0];
          if (be[1]) st_nx.bus_sec = wdata[15:8];
          if (be[2]) st_nx.bus_sub = wdata[23:16];
          if (be[3]) st_nx.lat_sec = wdata[31:24];
        end
        DW_IO: begin
          if (be[0]) st_nx.io_base = wdata[7:4];
          if (be[1]) st_nx.io_lim  = wdata[15:12];
        end
        DW_MEM: begin
          if (be[0]) st_nx.mem_base[3:0]  = wdata[7:4];
          if (be[1]) st_nx.mem_base[11:4] = wdata[15:8];
          if (be[2]) st_nx.mem_lim[3:0]   = wdata[23:20];
          if (be[3]) st_nx.mem_lim[11:4]  = wdata[31:24];
        end
        DW_PF: begin
          if (be[0]) st_nx.pf_base[3:0]  = wdata[7:4];
          if (be[1]) st_nx.pf_base[11:4] = wdata[15:8];
          if (be[2]) st_nx.pf_lim[3:0]   = wdata[23:20];
          if (be[3]) st_nx.pf_lim[11:4]  = wdata[31:24];
        end
        DW_PFBU: for (int l = 0; l < BE_W; l++)
                   if (be[l]) st_nx.pf_base_up[8*l +: 8] = wdata[8*l +: 8];
        DW_PFLU: for (int l = 0; l < BE_W; l++)
                   if (be[l]) st_nx.pf_lim_up[8*l +: 8] = wdata[8*l +: 8];
        DW_IOU: begin
          if (be[0]) st_nx.io_base_up[7:0]  = wdata[7:0];
          if (be[1]) st_nx.io_base_up[15:8] = wdata[15:8];
          if (be[2]) st_nx.io_lim_up[7:0]   = wdata[23:16];
          if (be[3]) st_nx.io_lim_up[15:8]  = wdata[31:24];
        end
        DW_CTL: begin
          if (be[2]) st_nx.ctl[7:0]  = wdata[23:16] & CTL_WMASK[7:0];
          if (be[3]) st_nx.ctl[15:8] = wdata[31:24] & CTL_WMASK[15:8];
        end
        default: ;
      endcase
    end
    // Extension registers exist only for the configured variants.
    if (!PREF64) begin
      st_nx.pf_base_up = '0;
      st_nx.pf_lim_up  = '0;
    end
    if (!IO32) begin
      st_nx.io_base_up = '0;
      st_nx.io_lim_up  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '0;
    else if (upd_en) st_q <= st_nx;
  end

  assign st = st_q;

  AST_CLOSE_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dis) && $past(rst_n)) |-> (st_q.io_base == '1 && st_q.io_lim == '0 &&
      st_q.mem_base == '1 && st_q.mem_lim == '0 && st_q.pf_base == '1 &&
      st_q.pf_lim == '0 && st_q.pf_base_up == '0 && st_q.pf_lim_up == '0)); // R10

  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.ctl & ~CTL_WMASK) == '0); // R6

endmodule

// File: rtl/p2p_cfg_events.sv
module p2p_cfg_events
  import p2p_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             dis,
  input  logic [IDX_W-1:0] addr,
  input  logic [BE_W-1:0]  be,
  input  logic             sbr_wbit,
  input  logic             sbr_cur,
  output logic             remap_pulse,
  output logic             sbr_pulse
);

  logic remap_nx;
  logic sbr_nx;
  logic remap_q;
  logic sbr_q;

  always_comb begin
    remap_nx = dis | (wr_en & fwd_span_hit(addr, be));
    sbr_nx   = wr_en & ~dis & (addr == DW_CTL) & be[2] & sbr_wbit & ~sbr_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
      sbr_q   <= 1'b0;
    end else begin
      remap_q <= remap_nx;
      sbr_q   <= sbr_nx;
    end
  end

  assign remap_pulse = remap_q;
  assign sbr_pulse   = sbr_q;

  AST_SBR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_q |-> (sbr_cur && !$past(sbr_cur))); // R9

  AST_SBR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_q |=> !sbr_q); // R9

  AST_REMAP_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dis) && $past(rst_n)) |-> remap_q); // R10

  AST_REMAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && !$past(dis)) |-> !remap_q); // R8

endmodule

// File: rtl/p2p_cfg_rdmux.sv
module p2p_cfg_rdmux
  import p2p_cfg_pkg::*;
#(
  parameter bit         IO32     = 1'b1,
  parameter bit         PREF64   = 1'b1,
  parameter bit         MULTI_FN = 1'b0,
  parameter logic [7:0] REV      = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  input  cfg_state_t        st,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [3:0] IO_TYPE = IO32   ? 4'h1 : 4'h0;
  localparam logic [3:0] PF_TYPE = PREF64 ? 4'h1 : 4'h0;

  logic [DATA_W-1:0] dw_nx;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    case (addr)
      DW_CMD:  dw_nx = {STAT_CAPS, 13'd0, st.cmd};
      DW_ID:   dw_nx = {CLASS_P2P, REV};
      DW_HDR:  dw_nx = {8'h00, MULTI_FN, 7'h01, 16'h0000};
      DW_BUS:  dw_nx = {st.lat_sec, st.bus_sub, st.bus_sec, st.bus_pri};
      DW_IO:   dw_nx = {STAT_CAPS, st.io_lim, IO_TYPE, st.io_base, IO_TYPE};
      DW_MEM:  dw_nx = {st.mem_lim, 4'h0, st.mem_base, 4'h0};
      DW_PF:   dw_nx = {st.pf_lim, PF_TYPE, st.pf_base, PF_TYPE};
      DW_PFBU: dw_nx = st.pf_base_up;
      DW_PFLU: dw_nx = st.pf_lim_up;
      DW_IOU:  dw_nx = {st.io_lim_up, st.io_base_up};
      DW_CTL:  dw_nx = {st.ctl, 16'h0000};
      default: dw_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= dw_nx;
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_en)) |-> $stable(rdata_q)); // R2

endmodule

// File: rtl/p2p_cfg_regs.sv
module p2p_cfg_regs
  import p2p_cfg_pkg::*;
#(
  parameter bit         IO_32BIT   = 1'b1,
  parameter bit         PREF_64BIT = 1'b1,
  parameter bit         MULTI_FUNC = 1'b0,
  parameter logic [7:0] REV_ID     = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic        fwd_disable,
  output logic [31:0] cfg_rdata,
  output logic        remap_pulse,
  output logic        sec_bus_rst_pulse
);

  cfg_state_t st;
  logic       wr_go;

  assign wr_go = cfg_wr & ~fwd_disable;

  p2p_cfg_store #(.IO32(IO_32BIT), .PREF64(PREF_64BIT)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_go (wr_go),
    .dis   (fwd_disable),
    .addr  (cfg_addr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .st    (st)
  );

  p2p_cfg_events u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr),
    .dis         (fwd_disable),
    .addr        (cfg_addr),
    .be          (cfg_be),
    .sbr_wbit    (cfg_wdata[16 + CTL_SBR]),
    .sbr_cur     (st.ctl[CTL_SBR]),
    .remap_pulse (remap_pulse),
    .sbr_pulse   (sec_bus_rst_pulse)
  );

  p2p_cfg_rdmux #(
    .IO32     (IO_32BIT),
    .PREF64   (PREF_64BIT),
    .MULTI_FN (MULTI_FUNC),
    .REV      (REV_ID)
  ) u_rdmux (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (cfg_rd),
    .addr  (cfg_addr),
    .st    (st),
    .rdata (cfg_rdata)
  );

endmodule

// File: tb/p2p_cfg_regs_bench.sv
`timescale 1ns/1ps
module p2p_cfg_regs_bench;

  localparam bit         P_IO32 = 1'b1;
  localparam bit         P_PF64 = 1'b1;
  localparam bit         P_MF   = 1'b0;
  localparam logic [7:0] P_REV  = 8'h02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fwd_disable = 1'b0;
  logic [31:0] cfg_rdata;
  logic        remap_pulse;
  logic        sec_bus_rst_pulse;

  always #2.5 clk = ~clk;

  p2p_cfg_regs #(.IO_32BIT(P_IO32), .PREF_64BIT(P_PF64), .MULTI_FUNC(P_MF), .REV_ID(P_REV))
  u_p2p_cfg_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .fwd_disable(fwd_disable),
    .cfg_rdata(cfg_rdata), .remap_pulse(remap_pulse), .sec_bus_rst_pulse(sec_bus_rst_pulse)
  );

  // Reference model: writable bits per byte address, plus expected outputs.
  logic [7:0]  mdl [0:63];
  logic [31:0] e_rd = '0;
  logic        e_rm = 1'b0;
  logic        e_sb = 1'b0;
  bit          started = 0;
  int          nvec = 0;
  int          nfail = 0;
  string       cur_req = "R1";
  bit          done = 0;

  function automatic logic [7:0] rom_b(int a);
    case (a)
      6, 30:  return 8'hA0;                       // R7 status capability bits
      8:      return P_REV;                       // R7
      10:     return 8'h04;                       // R7
      11:     return 8'h06;                       // R7
      14:     return {P_MF, 7'h01};               // R7
      28, 29: return P_IO32 ? 8'h01 : 8'h00;      // R4
      36, 38: return P_PF64 ? 8'h01 : 8'h00;      // R4
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wm_b(int a);
    if (a == 4) return 8'h07;                                  // R6
    if (a >= 24 && a <= 27) return 8'hFF;                      // R3
    if (a == 28 || a == 29) return 8'hF0;                      // R4
    if (a == 32 || a == 34 || a == 36 || a == 38) return 8'hF0; // R4
    if (a == 33 || a == 35 || a == 37 || a == 39) return 8'hFF; // R4
    if (a >= 40 && a <= 47) return P_PF64 ? 8'hFF : 8'h00;     // R5
    if (a >= 48 && a <= 51) return P_IO32 ? 8'hFF : 8'h00;     // R5
    if (a == 62) return 8'h4F;                                 // R6
    return 8'h00;
  endfunction

  function automatic bit in_span(int a);
    return (a == 4 || a == 5 || a == 28 || a == 29 || (a >= 32 && a <= 51) ||
            a == 62 || a == 63);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
      e_rd = '0; e_rm = 0; e_sb = 0;
    end else begin
      if (cfg_rd)
        for (int l = 0; l < 4; l++) e_rd[8*l +: 8] = rom_b(cfg_addr*4 + l) | mdl[cfg_addr*4 + l];
      e_rm = fwd_disable;
      if (cfg_wr)
        for (int l = 0; l < 4; l++) if (cfg_be[l] && in_span(cfg_addr*4 + l)) e_rm = 1;
      e_sb = 0;
      if (fwd_disable) begin
        mdl[28] = 8'hF0; mdl[29] = 8'h00;
        mdl[32] = 8'hF0; mdl[33] = 8'hFF; mdl[34] = 8'h00; mdl[35] = 8'h00;
        mdl[36] = 8'hF0; mdl[37] = 8'hFF; mdl[38] = 8'h00; mdl[39] = 8'h00;
        for (int i = 40; i < 48; i++) mdl[i] = 8'h00;
      end else if (cfg_wr) begin
        if (cfg_addr == 6'd15 && cfg_be[2] && cfg_wdata[22] && !mdl[62][6]) e_sb = 1;
        for (int l = 0; l < 4; l++)
          if (cfg_be[l])
            mdl[cfg_addr*4 + l] = cfg_wdata[8*l +: 8] & wm_b(cfg_addr*4 + l);
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      nvec++;
      if (cfg_rdata !== e_rd) begin
        nfail++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, cfg_rdata, e_rd);
      end
      if (remap_pulse !== e_rm) begin
        nfail++;
        $display("FAIL %s remap_pulse actual=%b expected=%b", cur_req, remap_pulse, e_rm);
      end
      if (sec_bus_rst_pulse !== e_sb) begin
        nfail++;
        $display("FAIL %s sec_bus_rst_pulse actual=%b expected=%b", cur_req, sec_bus_rst_pulse, e_sb);
      end
    end
  end

  task automatic op(input bit w, input bit r, input int a, input logic [3:0] b,
                    input logic [31:0] d, input bit ds);
    @(negedge clk);
    cfg_wr = w; cfg_rd = r; cfg_addr = 6'(a); cfg_be = b; cfg_wdata = d; fwd_disable = ds;
    @(negedge clk);
    cfg_wr = 0; cfg_rd = 0; cfg_be = '0; fwd_disable = 0;
  endtask

  task automatic wr(input int a, input logic [3:0] b, input logic [31:0] d);
    op(1, 0, a, b, d, 0);
  endtask

  task automatic rd(input int a);
    op(0, 1, a, 4'h0, 32'h0, 0);
  endtask

  task automatic rd_all();
    for (int i = 0; i < 16; i++) rd(i);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; rd_all();                           // R1 reset state
    cur_req = "R3";                                     // R3 bus numbers, lanes
    wr(6, 4'hF, 32'h44332211); rd(6);
    wr(6, 4'b0101, 32'hAABBCCDD); rd(6);
    cur_req = "R4";                                     // R4 windows and type bits
    wr(7, 4'hF, 32'hFFFFFFFF); rd(7);
    wr(8, 4'hF, 32'h12345678); rd(8);
    wr(9, 4'hF, 32'hFFFFFFFF); rd(9);
    wr(8, 4'b1010, 32'hA5A5A5A5); rd(8);
    cur_req = "R5";                                     // R5 upper extensions
    wr(10, 4'hF, 32'hDEADBEEF); wr(11, 4'b0011, 32'hCAFEF00D); wr(12, 4'hF, 32'h87654321);
    rd(10); rd(11); rd(12);
    cur_req = "R6";                                     // R6 command and bridge control
    wr(1, 4'hF, 32'hFFFFFFFF); wr(15, 4'hF, 32'hFFBFFFFF); rd(1); rd(15);
    cur_req = "R7";                                     // R7 fixed identification
    wr(2, 4'hF, 32'hFFFFFFFF); wr(3, 4'hF, 32'hFFFFFFFF);
    rd(1); rd(2); rd(3); rd(7);
    cur_req = "R8";                                     // R8 overlap boundaries
    wr(6, 4'hF, 32'h01020304); wr(13, 4'hF, 32'hFFFFFFFF); wr(15, 4'b0011, 32'hFFFFFFFF);
    wr(12, 4'b1000, 32'h11000000); wr(1, 4'b1100, 32'hFFFFFFFF); wr(1, 4'b0010, 32'h0);
    wr(7, 4'b1100, 32'hFFFFFFFF); wr(7, 4'b0001, 32'h000000F0); wr(8, 4'b0000, 32'hFFFFFFFF);
    wr(14, 4'hF, 32'h0); rd_all();
    cur_req = "R9";                                     // R9 rising edge only
    wr(15, 4'b0100, 32'h00000000);
    wr(15, 4'b0100, 32'h00400000); wr(15, 4'b0100, 32'h00400000);
    wr(15, 4'b0100, 32'h00000000); wr(15, 4'b0100, 32'h00400000);
    wr(15, 4'b0100, 32'h00000000); wr(15, 4'b1000, 32'hFFFFFFFF); rd(15);
    cur_req = "R2";                                     // R2 read during write
    op(1, 1, 6, 4'hF, 32'h5A5A5A5A, 0); rd(6);
    repeat (3) @(negedge clk);
    cur_req = "R10";                                    // R10 close windows
    op(0, 0, 0, 4'h0, 32'h0, 1); rd_all();
    op(1, 0, 15, 4'b0100, 32'h00400000, 1); rd(15);
    op(1, 0, 6, 4'hF, 32'h0, 1); rd(6);
    cur_req = "R1";                                     // R1 reset after activity
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd_all();
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule